// File: doc/BRIEF.md
# Aspect-Configurable Dual-Port RAM Block

This block is an embedded memory of 2304 bits. It has one synchronous write port and one synchronous read port, and each port has its own address. A two-bit organisation input sets how the storage is seen. It is either 128 words of 18 bits or 256 words of 9 bits. The organisation can be changed between accesses. The same physical rows stay behind both views, so data written in one view can be read back in the other.

Larger memories are built from several of these blocks. Placing blocks side by side with a shared address gives a wider word. Giving each block its own chip-enable gives more depth. A block whose enable is low neither writes nor changes its read output, so the surrounding logic selects which block's output to use.

Top module: `aspect_ram`

## Requirements
- R1: After reset is released, `rd_data` reads as all zeros until the first enabled read has completed.
- R2: With `org` = 2'b00, the block is 128 words of 18 bits. Each port addresses a row with its address bits [6:0], and address bit 7 is ignored.
- R3: With `org` = 2'b01, the block is 256 words of 9 bits. Address bits [7:1] pick the row and address bit 0 picks the half: 0 is row bits [8:0] and 1 is row bits [17:9]. The selected 9 bits appear on `rd_data[8:0]`, and `rd_data[17:9]` reads zero.
- R4: A write in the 9-bit organisation changes only the addressed half of its row. The other half keeps its contents.
- R5: The reserved `org` codes 2'b10 and 2'b11 behave exactly like 2'b00.
- R6: A read takes one cycle. `rd_data` changes only at the rising edge after the read address is presented, and there is no combinational path from `rd_addr` to `rd_data`.
- R7: When a read and a write hit the same location in the same cycle, the read returns the data held before that write.
- R8: While `ce` is low, writes do not happen and `rd_data` keeps its value, even if `org` or the addresses change.
- R9: Both organisations use the same storage. An 18-bit word at row r reads in the 9-bit organisation as address 2r (bits [8:0]) and address 2r+1 (bits [17:9]), and the reverse also holds.
- R10: In the 9-bit organisation, `wr_data[17:9]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the read path |
| org | input | 2 | Organisation select: 00 is 128x18, 01 is 256x9, other codes act as 00 |
| ce | input | 1 | Block enable for both ports |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address |
| wr_data | input | 18 | Write data; only bits [8:0] are used in the 9-bit organisation |
| rd_addr | input | 8 | Read address |
| rd_data | output | 18 | Registered read data |

## Verification
A wrong half-lane write enable corrupts the neighbouring 9-bit word in the same row. This shows only when that word is read next, so the bench reads back every location in both organisations after each sweep. A read-select register that fails to hold while `ce` is low makes `rd_data` change on the very next edge, and the hold checks compare one cycle later. A wrong row or half mapping shows as a mismatch on the first readback of an affected address, which the exhaustive sweeps reach within a few hundred cycles.

// File: rtl/aspect_ram_pkg.sv
package aspect_ram_pkg;

  typedef enum logic [1:0] {
    ORG_WIDE   = 2'b00,
    ORG_NARROW = 2'b01,
    ORG_RSV_A  = 2'b10,
    ORG_RSV_B  = 2'b11
  } org_e;

  // Only the narrow code selects the 9-bit view; every other code is wide.
  function automatic logic org_is_narrow(input logic [1:0] code);
    return code == ORG_NARROW;
  endfunction

  // Lane write enables: lane 0 is the low half, lane 1 the high half.
  function automatic logic [1:0] lane_enables(input logic fire,
                                              input logic narrow,
                                              input logic half);
    logic [1:0] en;
    en[0] = fire & (~narrow | ~half);
    en[1] = fire & (~narrow | half);
    return en;
  endfunction

endpackage

// File: rtl/aspect_ram_addr_map.sv
module aspect_ram_addr_map #(
  parameter int AW = 8
) (
  input  logic          narrow,
  input  logic [AW-1:0] addr,
  output logic [AW-2:0] row,
  output logic          half
);
  localparam int RW = AW - 1;

  always_comb begin
    if (narrow) begin
      row  = addr[AW-1:1];
      half = addr[0];
    end else begin
      row  = addr[RW-1:0];
      half = 1'b0;
    end
  end
endmodule

// File: rtl/aspect_ram_store.sv
module aspect_ram_store #(
  parameter int ROWS   = 128,
  parameter int HALF_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  lane_wen,
  input  logic [$clog2(ROWS)-1:0]     wr_row,
  input  logic [2*HALF_W-1:0]         wr_word,
  input  logic                        rd_fire,
  input  logic [$clog2(ROWS)-1:0]     rd_row,
  output logic [2*HALF_W-1:0]         rd_word
);
  localparam int LANES = 2;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [HALF_W-1:0] mem [ROWS];
    logic [HALF_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_wen[ln]) mem[wr_row] <= wr_word[ln*HALF_W +: HALF_W];
    end

    // Registered read samples the array before this edge's write: old data.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (rd_fire) q <= mem[rd_row];
    end

    assign rd_word[ln*HALF_W +: HALF_W] = q;
  end
endmodule

// File: rtl/aspect_ram_rd_fmt.sv
module aspect_ram_rd_fmt #(
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_fire,
  input  logic                narrow,
  input  logic                half,
  input  logic [2*HALF_W-1:0] row_q,
  output logic [2*HALF_W-1:0] rd_data
);
  logic narrow_q;
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      half_q   <= 1'b0;
    end else if (rd_fire) begin
      narrow_q <= narrow;
      half_q   <= half;
    end
  end

  always_comb begin
    if (narrow_q)
      rd_data = {{HALF_W{1'b0}},
                 half_q ? row_q[2*HALF_W-1:HALF_W] : row_q[HALF_W-1:0]};
    else
      rd_data = row_q;
  end
endmodule

// File: rtl/aspect_ram.sv
module aspect_ram #(
  parameter int ROWS  = 128,
  parameter int ROW_W = 18,
  parameter int AW    = $clog2(ROWS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       org,
  input  logic             ce,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_data
);
  import aspect_ram_pkg::*;

  localparam int HALF_W = ROW_W / 2;
  localparam int RW     = AW - 1;

  // Named internal events, brought out for the checker.
  logic          narrow;
  logic          wr_fire;
  logic          rd_fire;
  logic [RW-1:0] wr_row;
  logic [RW-1:0] rd_row;
  logic          wr_half;
  logic          rd_half;
  logic [1:0]    lane_wen;
  logic [ROW_W-1:0] wr_word;
  logic [ROW_W-1:0] row_q;

  assign narrow  = org_is_narrow(org);
  assign wr_fire = ce & wr_en;
  assign rd_fire = ce;

  aspect_ram_addr_map #(.AW(AW)) u_wmap (
    .narrow (narrow),
    .addr   (wr_addr),
    .row    (wr_row),
    .half   (wr_half)
  );

  aspect_ram_addr_map #(.AW(AW)) u_rmap (
    .narrow (narrow),
    .addr   (rd_addr),
    .row    (rd_row),
    .half   (rd_half)
  );

  assign lane_wen = lane_enables(wr_fire, narrow, wr_half);
  // In the narrow view the 9-bit word is replicated to both lanes.
  assign wr_word  = narrow ? {wr_data[HALF_W-1:0], wr_data[HALF_W-1:0]} : wr_data;

  aspect_ram_store #(.ROWS(ROWS), .HALF_W(HALF_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_wen (lane_wen),
    .wr_row   (wr_row),
    .wr_word  (wr_word),
    .rd_fire  (rd_fire),
    .rd_row   (rd_row),
    .rd_word  (row_q)
  );

  aspect_ram_rd_fmt #(.HALF_W(HALF_W)) u_fmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .narrow  (narrow),
    .half    (rd_half),
    .row_q   (row_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/aspect_ram_chk.sv
module aspect_ram_chk #(
  parameter int ROW_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       org,
  input logic             ce,
  input logic             wr_en,
  input logic [ROW_W-1:0] rd_data,
  input logic             wr_fire,
  input logic [1:0]       lane_wen
);
  localparam int HALF_W = ROW_W / 2;

  // R1: first edge after reset release still shows the cleared output
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  // R8: output frozen while disabled
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(rd_data));

  // R8: no lane is written while disabled
  a_r8_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> lane_wen == 2'b00);

  // R3: narrow read leaves the upper half of the output at zero
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && org == 2'b01) |=> rd_data[ROW_W-1:HALF_W] == '0);

  // R4: a narrow write touches exactly one lane
  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && org == 2'b01) |-> $countones(lane_wen) == 1);

  // R2 and R5: a write in any non-narrow code writes both lanes
  a_r5_wide_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wr_en && org != 2'b01) |-> lane_wen == 2'b11);
endmodule

bind aspect_ram aspect_ram_chk #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .org      (org),
  .ce       (ce),
  .wr_en    (wr_en),
  .rd_data  (rd_data),
  .wr_fire  (wr_fire),
  .lane_wen (lane_wen)
);

// File: tb/aspect_ram_bench.sv
`timescale 1ns/1ps
module aspect_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  org = 2'b00;
  logic        ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [17:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [17:0] model [128];

  always #5 clk = ~clk;

  aspect_ram u_aspect_ram (
    .clk(clk), .rst_n(rst_n), .org(org), .ce(ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [17:0] expect_rd(input logic [1:0] m, input logic [7:0] a);
    int r;
    if (m == 2'b01) begin
      r = int'(a) / 2;
      if (a % 2 == 1) return {9'd0, model[r][17:9]};
      else            return {9'd0, model[r][8:0]};
    end
    r = int'(a) % 128;
    return model[r];
  endfunction

  function automatic logic [17:0] pat18(input int i);
    return 18'((i * 1237 + 91) % 262144);
  endfunction

  function automatic logic [8:0] pat9(input int i);
    return 9'((i * 53 + 7) % 512);
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] m, input logic [7:0] a, input logic [17:0] d);
    int r;
    org = m; ce = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (m == 2'b01) begin
      r = int'(a) / 2;
      if (a % 2 == 1) model[r][17:9] = d[8:0];
      else            model[r][8:0]  = d[8:0];
    end else begin
      model[int'(a) % 128] = d;
    end
  endtask

  task automatic do_read(input logic [1:0] m, input logic [7:0] a, input string tag);
    org = m; ce = 1'b1; rd_addr = a;
    @(negedge clk);
    check(tag, rd_data, expect_rd(m, a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", rd_data, 18'd0);

    // R2: wide sweep
    for (int i = 0; i < 128; i++) do_write(2'b00, 8'(i), pat18(i));
    for (int i = 0; i < 128; i++) do_read(2'b00, 8'(i), "R2 wide readback");
    for (int i = 0; i < 128; i += 9) do_read(2'b00, 8'(i + 128), "R2 addr bit7 ignored");
    // R9: wide data seen through the narrow view
    for (int i = 0; i < 256; i++) do_read(2'b01, 8'(i), "R9 wide to narrow");

    // R3 and R10: narrow sweep with junk on the unused data bits
    for (int i = 0; i < 256; i++)
      do_write(2'b01, 8'(i), {9'(i * 7 + 300), pat9(i)});
    for (int i = 0; i < 256; i++) do_read(2'b01, 8'(i), "R3 narrow readback");
    for (int i = 0; i < 128; i++) do_read(2'b00, 8'(i), "R9 R10 narrow to wide");

    // R4: half write keeps the other half
    do_write(2'b00, 8'd5, 18'h2AAAA);
    do_write(2'b01, 8'd11, 18'h3FE55);
    do_read(2'b00, 8'd5, "R4 upper half write");
    check("R4 lower half kept", rd_data, 18'h2AAAA & 18'h001FF | 18'h0AA00);
    do_write(2'b01, 8'd10, 18'h00033);
    do_read(2'b00, 8'd5, "R4 lower half write");

    // R5: reserved codes act wide
    do_write(2'b10, 8'h83, 18'h1234F);
    do_read(2'b11, 8'd3, "R5 reserved code 11");
    do_read(2'b00, 8'd3, "R5 reserved code 10 write");
    do_read(2'b10, 8'h03, "R5 reserved read");

    // R7: same-address read and write in one cycle
    do_read(2'b00, 8'd20, "R7 pre read");
    org = 2'b00; ce = 1'b1; rd_addr = 8'd20;
    wr_en = 1'b1; wr_addr = 8'd20; wr_data = 18'h15A5A;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 old data returned", rd_data, model[20]);
    model[20] = 18'h15A5A;
    do_read(2'b00, 8'd20, "R7 new data after");

    // R6: one cycle latency, no combinational path
    do_read(2'b00, 8'd30, "R6 setup read");
    rd_addr = 8'd31;
    #2;
    check("R6 no change before edge", rd_data, model[30]);
    @(negedge clk);
    check("R6 change after one edge", rd_data, model[31]);

    // R8: disabled block ignores writes and holds its output
    do_read(2'b00, 8'd40, "R8 setup read");
    held = rd_data;
    ce = 1'b0; wr_en = 1'b1; wr_addr = 8'd40; wr_data = ~model[40]; rd_addr = 8'd41;
    @(negedge clk);
    check("R8 output held", rd_data, held);
    org = 2'b01; rd_addr = 8'd81;
    @(negedge clk);
    check("R8 held across org change", rd_data, held);
    wr_en = 1'b0;
    do_read(2'b00, 8'd40, "R8 write ignored");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule